// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Increment Pointer

This block is a serial slave on a two-wire bus (open-drain clock and data lines) that owns a bank of 8-bit control registers and exposes a set of read-only status bytes supplied by the rest of the chip. It runs on a system clock that is fast compared with the bus. It brings both bus lines through two-stage synchronizers and detects start, stop and clock edges on the synchronized copies. It drives the data line only by pulling it low, through a single output-enable.

The slave answers two fixed address bytes. The byte 24h opens a write transfer. The next byte loads an internal register pointer, and every byte after it is stored at the pointer, which then steps by one. The byte 25h opens a read transfer that returns bytes from the current pointer onward and steps the pointer after each byte. The pointer is kept across stop conditions. A controller therefore sets the pointer with a short write that ends in a stop, and then opens a read. Control registers occupy addresses `0 .. NUM_CTRL-1`. Status bytes follow at `NUM_CTRL .. NUM_CTRL+NUM_STAT-1`. Every other address is unmapped.

Top module: `twr_slave`

## Requirements
- R1: After reset every control register output is 00h and the data line is not driven.
- R2: A stop (data rising while clock is high) returns the slave to idle and releases the data line. A start (data falling while clock is high) begins a new address byte from any state, including in the middle of a byte or of a transfer. A byte cut short by stop or start has no effect.
- R3: The slave acknowledges (pulls data low during the 9th clock) the address bytes 24h (write) and 25h (read). Any other address byte is not acknowledged, and the rest of that transfer is ignored (no acknowledge, no register change) until the next start.
- R4: Bytes are received MSB first, 8 data clocks plus one acknowledge clock. In a write, the first byte after 24h loads the register pointer and is acknowledged.
- R5: Each later write byte is acknowledged and stored at the pointer, which then increments by one, wrapping from FFh to 00h. The number of bytes per transfer is unlimited.
- R6: Write bytes aimed at status or unmapped addresses are acknowledged but change no register, and the pointer still increments.
- R7: A read returns, MSB first, the control register value, the status byte (status byte k at address NUM_CTRL+k, taken from bits 8k+7..8k of the status input), or 00h for unmapped addresses. The pointer increments after each byte.
- R8: During a read, a low acknowledge from the master requests the next byte. A high acknowledge ends the read: the slave leaves the data line released (further clocks read FFh) until stop or start.
- R9: The pointer keeps its value across stop. A read opened after a write returns data from the pointer as that write left it.
- R10: The slave changes its drive of the data line only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| status_i | input | NUM_STAT*8 | Read-only status bytes, byte k in bits 8k+7..8k |
| ctrl_o | output | NUM_CTRL*8 | Control registers, register k in bits 8k+7..8k |

## Verification
The hardest conditions to reach from the ports are those where the bus is broken off: a stop or start in the middle of a byte, a start repeated without a stop, and a read that the master has already ended with a high acknowledge but keeps clocking. The bench drives both lines bit by bit through a model of the open-drain line. This lets it cut a byte after four bits, insert a second start straight after a pointer byte, and clock one extra byte after the closing acknowledge, checking that only ones come back. A full sweep writes every control address, every status address and one unmapped address, then reads the whole map back in a single burst. A pointer set to FFh checks the wrap.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_MACK, ST_IGN
  } twr_state_e;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} twr_kind_e;

  localparam logic [7:0] DEV_WR = 8'h24;
  localparam logic [7:0] DEV_RD = 8'h25;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, synced, prev;
  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '1;
    else         prev <= synced;
  end

  assign scl_o      = synced[1];
  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~prev[1];
  assign scl_fall_o = ~synced[1] & prev[1];
  // data edge with clock held high on both samples
  assign start_o    = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_o     = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/twr_proto.sv
module twr_proto
  import twr_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic [PTR_W-1:0] ptr_o,
  output twr_state_e       state_o,
  output logic             sda_oe_o
);
  twr_state_e       state;
  twr_kind_e        kind;
  logic             rd_mode, pend, ack_ok, mack;
  logic [2:0]       cnt;
  logic [7:0]       shreg, txsh;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rx_byte;

  assign rx_byte = {shreg[6:0], sda_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      rd_mode   <= 1'b0;
      pend      <= 1'b0;
      ack_ok    <= 1'b0;
      mack      <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        state <= ST_IDLE;
        pend  <= 1'b0;
      end else if (start_i) begin
        state <= ST_RX;
        kind  <= K_ADDR;
        cnt   <= '0;
        pend  <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise_i) begin
              shreg <= rx_byte;
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                pend <= 1'b1;
                unique case (kind)
                  K_ADDR: begin
                    if (rx_byte == DEV_WR) begin
                      ack_ok <= 1'b1; rd_mode <= 1'b0; kind <= K_PTR;
                    end else if (rx_byte == DEV_RD) begin
                      ack_ok <= 1'b1; rd_mode <= 1'b1; kind <= K_DATA;
                    end else begin
                      ack_ok <= 1'b0;
                    end
                  end
                  K_PTR: begin
                    ptr    <= rx_byte[PTR_W-1:0];
                    ack_ok <= 1'b1;
                    kind   <= K_DATA;
                  end
                  default: begin
                    wr_en_o   <= 1'b1;
                    wr_addr_o <= ptr;
                    wr_data_o <= rx_byte;
                    ptr       <= ptr + PTR_W'(1);
                    ack_ok    <= 1'b1;
                  end
                endcase
              end
            end else if (scl_fall_i && pend) begin
              pend  <= 1'b0;
              state <= ack_ok ? ST_RACK : ST_IGN;
            end
          end
          ST_RACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rd_mode) begin
                state <= ST_TX;
                txsh  <= rd_data_i;
                ptr   <= ptr + PTR_W'(1);
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              txsh <= {txsh[6:0], 1'b0};
              cnt  <= cnt + 3'd1;
              if (cnt == 3'd7) state <= ST_MACK;
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                state <= ST_TX;
                txsh  <= rd_data_i;
                ptr   <= ptr + PTR_W'(1);
                cnt   <= '0;
              end else begin
                state <= ST_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o    = ptr;
  assign state_o  = state;
  assign sda_oe_o = (state == ST_RACK) || (state == ST_TX && !txsh[7]);
endmodule

// File: rtl/twr_regbank.sv
module twr_regbank #(
  parameter int NUM_CTRL = 16,
  parameter int NUM_STAT = 4,
  parameter int PTR_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [PTR_W-1:0]      wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [PTR_W-1:0]      rd_addr_i,
  input  logic [NUM_STAT*8-1:0] status_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic [7:0] regs [NUM_CTRL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CTRL; i++) regs[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (wr_addr_i == PTR_W'(i)) regs[i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_out
    assign ctrl_o[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr_i == PTR_W'(i)) rd_data_o = regs[i];
    for (int j = 0; j < NUM_STAT; j++)
      if (rd_addr_i == PTR_W'(NUM_CTRL + j)) rd_data_o = status_i[j*8 +: 8];
  end
endmodule

// File: rtl/twr_slave.sv
module twr_slave
  import twr_pkg::*;
#(
  parameter int NUM_CTRL = 16,
  parameter int NUM_STAT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [NUM_STAT*8-1:0] status_i,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  localparam int PTR_W = 8;

  logic             scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, ptr;
  logic [7:0]       wr_data, rd_data;
  twr_state_e       state;

  twr_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  twr_proto #(.PTR_W(PTR_W)) u_proto (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt),
    .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .ptr_o(ptr), .state_o(state), .sda_oe_o
  );

  twr_regbank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT), .PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(ptr), .status_i, .rd_data_o(rd_data), .ctrl_o
  );
endmodule

// File: rtl/twr_slave_chk.sv
module twr_slave_chk
  import twr_pkg::*;
#(
  parameter int NUM_CTRL = 16,
  parameter int PTR_W    = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  start_evt,
  input logic                  stop_evt,
  input logic                  sda_oe_o,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_addr,
  input logic [PTR_W-1:0]      ptr,
  input twr_state_e            state,
  input logic [NUM_CTRL*8-1:0] ctrl_o
);
  // R10
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && !start_evt && !stop_evt) |-> $stable(sda_oe_o));

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> (!sda_oe_o && state == ST_IDLE));

  // R2
  start_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_evt && !stop_evt) |=> state == ST_RX);

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ptr == wr_addr + PTR_W'(1));

  // R6
  ctrl_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> ($past(wr_en) && $past(wr_addr) < PTR_W'(NUM_CTRL)));

  // R3
  ign_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IGN |-> !sda_oe_o);
endmodule

bind twr_slave twr_slave_chk #(.NUM_CTRL(NUM_CTRL), .PTR_W(PTR_W)) u_chk (
  .clk_i, .rst_ni, .scl_s, .start_evt, .stop_evt, .sda_oe_o,
  .wr_en, .wr_addr, .ptr, .state, .ctrl_o
);

// File: tb/twr_slave_tb.sv
module twr_slave_tb;
  localparam int NUM_CTRL = 16;
  localparam int NUM_STAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NUM_STAT*8-1:0] status = 32'hD35A813C;
  logic [NUM_CTRL*8-1:0] ctrl;

  int n_chk = 0, n_fail = 0, viol = 0;
  logic [7:0] exp_reg [NUM_CTRL];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twr_slave #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .status_i(status), .ctrl_o(ctrl)
  );

  // R10 monitor: drive changes while bus clock is high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(posedge clk) begin
    #5;
    if (rst_n && scl && prev_scl && sda_oe != prev_oe) viol++;
    prev_scl = scl;
    prev_oe  = sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 29 + 3);
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a < NUM_CTRL) return exp_reg[a];
    if (a < NUM_CTRL + NUM_STAT) return status[(a - NUM_CTRL)*8 +: 8];
    return 8'h00;
  endfunction

  task automatic bus_start();
    scl = 1'b0; wait_clk(6);
    sda_m = 1'b1; wait_clk(4);
    scl = 1'b1; wait_clk(6);
    sda_m = 1'b0; wait_clk(6);
  endtask

  task automatic bus_stop();
    scl = 1'b0; wait_clk(6);
    sda_m = 1'b0; wait_clk(4);
    scl = 1'b1; wait_clk(6);
    sda_m = 1'b1; wait_clk(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl = 1'b0; wait_clk(5);
      sda_m = b[i]; wait_clk(5);
      scl = 1'b1; wait_clk(10);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    scl = 1'b0; wait_clk(2);
    sda_m = 1'b1; wait_clk(8);
    scl = 1'b1; wait_clk(5);
    ack = ~sda_line; wait_clk(5);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; wait_clk(2);
      sda_m = 1'b1; wait_clk(8);
      scl = 1'b1; wait_clk(5);
      d[i] = sda_line; wait_clk(5);
    end
    scl = 1'b0; wait_clk(5);
    sda_m = last ? 1'b1 : 1'b0; wait_clk(5);
    scl = 1'b1; wait_clk(10);
  endtask

  task automatic check_ctrl(input string req);
    for (int i = 0; i < NUM_CTRL; i++)
      check(ctrl[i*8 +: 8] == exp_reg[i], req, ctrl[i*8 +: 8], exp_reg[i]);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < NUM_CTRL; i++) exp_reg[i] = 8'h00;
    wait_clk(5);
    // R1: reset state
    check(ctrl == '0, "R1 ctrl reset", ctrl[31:0], 0);
    check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // full write sweep, then status/unmapped tail in same transfer
    bus_start();
    send_byte(8'h24, ack); check(ack, "R3 write address ack", ack, 1);
    send_byte(8'h00, ack); check(ack, "R4 pointer byte ack", ack, 1);
    for (int i = 0; i < NUM_CTRL; i++) begin
      send_byte(pat(i), ack);
      check(ack, "R5 data ack", ack, 1);
      exp_reg[i] = pat(i);
    end
    for (int i = 0; i < NUM_STAT + 1; i++) begin
      send_byte(8'hEE, ack);
      check(ack, "R6 status/unmapped write ack", ack, 1);
    end
    bus_stop();
    check_ctrl("R5 sweep stored");
    check_ctrl("R6 status writes ignored");

    // pointer set, then full-map burst read
    bus_start();
    send_byte(8'h24, ack);
    send_byte(8'h00, ack);
    bus_stop();
    bus_start();
    send_byte(8'h25, ack); check(ack, "R3 read address ack", ack, 1);
    for (int a = 0; a < NUM_CTRL + NUM_STAT + 2; a++) begin
      recv_byte(a == NUM_CTRL + NUM_STAT + 1, d);
      check(d == exp_rd(a), "R7 R4 burst read", d, exp_rd(a));
    end
    // R8: after high acknowledge, slave stays silent
    recv_byte(1'b1, d);
    check(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    check(sda_oe == 1'b0, "R8 oe low", sda_oe, 0);
    bus_stop();

    // R9: pointer kept across stop, advanced by write
    bus_start();
    send_byte(8'h24, ack);
    send_byte(8'h05, ack);
    send_byte(8'hA5, ack);
    bus_stop();
    exp_reg[5] = 8'hA5;
    bus_start();
    send_byte(8'h25, ack);
    recv_byte(1'b1, d);
    check(d == exp_reg[6], "R9 read follows write pointer", d, exp_reg[6]);
    bus_stop();
    check(ctrl[5*8 +: 8] == 8'hA5, "R5 single write", ctrl[5*8 +: 8], 8'hA5);

    // R3: foreign addresses
    bus_start();
    send_byte(8'h26, ack); check(!ack, "R3 foreign nack 26h", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R3 ignored pointer", ack, 0);
    send_byte(8'h77, ack); check(!ack, "R3 ignored data", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h48, ack); check(!ack, "R3 foreign nack 48h", ack, 0);
    send_byte(8'h99, ack);
    bus_stop();
    check_ctrl("R3 ignored transfer");

    // R2: repeated start without stop
    bus_start();
    send_byte(8'h24, ack);
    send_byte(8'h03, ack);
    bus_start();
    send_byte(8'h25, ack); check(ack, "R2 repeated start ack", ack, 1);
    recv_byte(1'b1, d);
    check(d == exp_reg[3], "R2 repeated start read", d, exp_reg[3]);
    bus_stop();

    // R2: stop in the middle of a data byte
    bus_start();
    send_byte(8'h24, ack);
    send_byte(8'h02, ack);
    send_bits(8'h00, 4);
    bus_stop();
    check(ctrl[2*8 +: 8] == exp_reg[2], "R2 cut byte no effect", ctrl[2*8 +: 8], exp_reg[2]);

    // R5: pointer wrap FFh -> 00h
    bus_start();
    send_byte(8'h24, ack);
    send_byte(8'hFF, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack); check(ack, "R5 wrap ack", ack, 1);
    bus_stop();
    exp_reg[0] = 8'h22;
    check_ctrl("R5 pointer wrap");

    // R10
    check(viol == 0, "R10 drive change under high clock", viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule